// File: doc/BRIEF.md
# Cache Block Zero Allocation Unit

This unit is the control and storage core of a small direct-mapped, write-back data cache, built around one operation: clearing a whole cache block to zero. A request carries a base operand, an index operand and a flag that says the base register field is zero. The unit forms the effective address and checks the permission and page attribute inputs. It then either clears a resident line, or claims a line for the address and fills it with zeros without reading memory, or refuses the request with an exception status. Every line it clears is left dirty. A dirty line of another address in the target set is first written back through a word-wide memory write port.

A caller presents a request while `busy` is low. The unit answers with a one-cycle `done_ack` and a two-bit status: 0 for success, 1 for the alignment exception, 2 for the data storage exception and 3 for a machine check. The attribute and fault inputs must stay steady from the request until the acknowledge. The default geometry is 32-bit addresses, 32-bit words, 8 words per line and 8 sets. Address bits [4:0] are the line offset, [7:5] select the set and [31:8] are the tag.

Top module: `blkz_unit`

## Requirements
- R1: The effective address is `req_index + req_base`, or `req_index` alone when `req_base_zero` is 1, with modulo 2^32 wrap. The offset bits [4:0] have no effect: the block containing the address is the one cleared and tagged.
- R2: When `perm_store_fault` is 1 the request ends with status 2, two cycles after acceptance, and leaves the cache unchanged. This check wins over the attribute check.
- R3: With no store fault, a page that is not cacheable (`attr_cacheable` 0) or is write-through (`attr_write_thru` 1) ends with status 1 two cycles after acceptance, leaves the cache unchanged and starts no memory write.
- R4: A request that hits a resident line in an allowed page clears all of its words to zero, leaves it valid and dirty, starts no memory write, and acknowledges with status 0 ten cycles after acceptance.
- R5: A miss whose target set holds no dirty valid line claims the set for the new tag, zero-filled and dirty. It does so with no memory traffic at all and acknowledges with status 0 ten cycles after acceptance.
- R6: A miss whose target set holds a dirty valid line of another tag first writes that line back as 8 word beats at ascending byte addresses `{old tag, set, word, 2'b00}`, carrying the line's contents. Each beat is held until `mem_wr_ready` is 1. Zeroing takes 8 more cycles after the last beat.
- R7: If `mem_wr_err` is 1 on any accepted writeback beat, the request finishes with status 3. The new line is still installed, zeroed and dirty.
- R8: The record bit `req_record` has no effect on status, timing, memory traffic or cache state.
- R9: A request is accepted on a clock edge with `req_valid` 1 and `busy` 0. `busy` is 1 from the next cycle until the acknowledge. `done_ack` is high for exactly one cycle, with `busy` 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_base | input | 32 | Base operand |
| req_index | input | 32 | Index operand |
| req_base_zero | input | 1 | Base register field is zero; use constant 0 as base |
| req_record | input | 1 | Record bit of the instruction form, no effect |
| attr_cacheable | input | 1 | Page is cacheable |
| attr_write_thru | input | 1 | Page is write-through |
| perm_store_fault | input | 1 | Store permission fault for the address |
| busy | output | 1 | Operation in progress |
| done_ack | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 OK, 1 alignment, 2 data storage, 3 machine check |
| mem_wr_valid | output | 1 | Writeback beat valid |
| mem_wr_ready | input | 1 | Memory takes the current beat |
| mem_wr_addr | output | 32 | Byte address of the writeback word |
| mem_wr_data | output | 32 | Writeback word |
| mem_wr_err | input | 1 | Bus error on the beat taken this cycle |

## Verification
The assertions take for granted that `mem_wr_err` only matters on a cycle with `mem_wr_ready` high. They also take for granted that the attribute and fault inputs do not change while a request is in flight, because the decision samples them one cycle after acceptance. The bench drives attributes together with the request and holds them until the acknowledge. It raises `req_valid` only when the unit is idle, and it raises the error input only together with ready. It stalls the write port for several cycles on some beats, which exercises the beat-hold property.

// File: rtl/blkz_pkg.sv
package blkz_pkg;
   typedef enum logic [1:0] {
      ST_OK    = 2'd0,
      ST_ALIGN = 2'd1,
      ST_DSE   = 2'd2,
      ST_MCHK  = 2'd3
   } blkz_status_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DECIDE,
      PH_WBACK,
      PH_ZERO
   } blkz_phase_e;
endpackage

// File: rtl/blkz_tag_store.sv
module blkz_tag_store #(
   parameter int SETS  = 8,
   parameter int TAG_W = 24,
   localparam int SET_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] sel_set,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_valid,
   output logic             rd_dirty,
   input  logic             wr_en,
   input  logic [TAG_W-1:0] wr_tag
);
   logic [TAG_W-1:0] tag_a   [SETS];
   logic [SETS-1:0]  valid_a;
   logic [SETS-1:0]  dirty_a;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic hit_wr;
      assign hit_wr = wr_en && (sel_set == SET_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_a[s] <= 1'b0;
            dirty_a[s] <= 1'b0;
         end else if (hit_wr) begin
            valid_a[s] <= 1'b1;
            dirty_a[s] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (hit_wr) tag_a[s] <= wr_tag;
      end
   end

   assign rd_tag   = tag_a[sel_set];
   assign rd_valid = valid_a[sel_set];
   assign rd_dirty = dirty_a[sel_set];
endmodule

// File: rtl/blkz_data_store.sv
module blkz_data_store #(
   parameter int SETS       = 8,
   parameter int LINE_WORDS = 8,
   parameter int WORD_W     = 32,
   localparam int SET_W = $clog2(SETS),
   localparam int CNT_W = $clog2(LINE_WORDS)
) (
   input  logic              clk,
   input  logic [SET_W-1:0]  sel_set,
   input  logic [CNT_W-1:0]  sel_word,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] words_a [SETS*LINE_WORDS];
   logic [SET_W+CNT_W-1:0] flat_idx;

   assign flat_idx = {sel_set, sel_word};

   always_ff @(posedge clk) begin
      if (wr_en) words_a[flat_idx] <= wr_data;
   end

   assign rd_data = words_a[flat_idx];
endmodule

// File: rtl/blkz_ctrl.sv
module blkz_ctrl
   import blkz_pkg::*;
#(
   parameter int SET_W      = 3,
   parameter int TAG_W      = 24,
   parameter int LINE_WORDS = 8,
   localparam int CNT_W = $clog2(LINE_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [SET_W-1:0] req_set,
   input  logic [TAG_W-1:0] req_tag,
   input  logic             attr_cacheable,
   input  logic             attr_write_thru,
   input  logic             perm_store_fault,
   input  logic [TAG_W-1:0] rd_tag,
   input  logic             rd_valid,
   input  logic             rd_dirty,
   input  logic             mem_wr_ready,
   input  logic             mem_wr_err,
   output logic             busy,
   output logic             done_ack,
   output blkz_status_e     done_status,
   output logic [SET_W-1:0] set_q,
   output logic [TAG_W-1:0] vtag_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             tag_wr_en,
   output logic             data_wr_en,
   output logic             mem_wr_valid
);
   localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(LINE_WORDS - 1);

   blkz_phase_e  phase_q;
   logic [TAG_W-1:0] tag_q;
   logic         err_q;
   logic         ack_q;
   blkz_status_e stat_q;
   logic         hit;

   assign hit          = rd_valid && (rd_tag == tag_q);
   assign busy         = (phase_q != PH_IDLE);
   assign mem_wr_valid = (phase_q == PH_WBACK);
   assign data_wr_en   = (phase_q == PH_ZERO);
   assign tag_wr_en    = (phase_q == PH_ZERO) && (cnt_q == LAST_WORD);
   assign done_ack     = ack_q;
   assign done_status  = stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         set_q   <= '0;
         tag_q   <= '0;
         vtag_q  <= '0;
         cnt_q   <= '0;
         err_q   <= 1'b0;
         ack_q   <= 1'b0;
         stat_q  <= ST_OK;
      end else begin
         ack_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (req_valid) begin
                  set_q   <= req_set;
                  tag_q   <= req_tag;
                  err_q   <= 1'b0;
                  cnt_q   <= '0;
                  phase_q <= PH_DECIDE;
               end
            end
            PH_DECIDE: begin
               if (perm_store_fault) begin
                  ack_q   <= 1'b1;
                  stat_q  <= ST_DSE;
                  phase_q <= PH_IDLE;
               end else if (!attr_cacheable || attr_write_thru) begin
                  ack_q   <= 1'b1;
                  stat_q  <= ST_ALIGN;
                  phase_q <= PH_IDLE;
               end else if (!hit && rd_valid && rd_dirty) begin
                  vtag_q  <= rd_tag;
                  phase_q <= PH_WBACK;
               end else begin
                  phase_q <= PH_ZERO;
               end
            end
            PH_WBACK: begin
               if (mem_wr_ready) begin
                  err_q <= err_q | mem_wr_err;
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == LAST_WORD) phase_q <= PH_ZERO;
               end
            end
            PH_ZERO: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST_WORD) begin
                  ack_q   <= 1'b1;
                  stat_q  <= err_q ? ST_MCHK : ST_OK;
                  phase_q <= PH_IDLE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/blkz_unit.sv
module blkz_unit
   import blkz_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 8,
   parameter int SETS       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [ADDR_W-1:0] req_index,
   input  logic              req_base_zero,
   input  logic              req_record,
   input  logic              attr_cacheable,
   input  logic              attr_write_thru,
   input  logic              perm_store_fault,
   output logic              busy,
   output logic              done_ack,
   output logic [1:0]        done_status,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [WORD_W-1:0] mem_wr_data,
   input  logic              mem_wr_err
);
   localparam int BYTE_W = $clog2(WORD_W / 8);
   localparam int CNT_W  = $clog2(LINE_WORDS);
   localparam int OFF_W  = CNT_W + BYTE_W;
   localparam int SET_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

   initial begin
      assert (WORD_W % 8 == 0 && (WORD_W / 8 & (WORD_W / 8 - 1)) == 0)
         else $error("WORD_W must be a power-of-two number of bytes");
      assert (LINE_WORDS >= 2 && (LINE_WORDS & (LINE_WORDS - 1)) == 0)
         else $error("LINE_WORDS must be a power of two");
      assert (SETS >= 2 && (SETS & (SETS - 1)) == 0)
         else $error("SETS must be a power of two");
      assert (TAG_W >= 1) else $error("address too narrow for geometry");
   end

   logic [ADDR_W-1:0] eff_addr;
   logic [TAG_W-1:0]  rd_tag, vtag_q;
   logic              rd_valid, rd_dirty, tag_wr_en, data_wr_en;
   logic [SET_W-1:0]  set_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [TAG_W-1:0]  cur_tag_q;
   blkz_status_e      stat;
   logic              unused_bits;

   assign eff_addr    = req_index + (req_base_zero ? '0 : req_base);
   assign unused_bits = ^{req_record, eff_addr[OFF_W-1:0]};

   // Tag to install is captured alongside the request.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cur_tag_q <= '0;
      else if (req_valid && !busy) cur_tag_q <= eff_addr[ADDR_W-1 -: TAG_W];
   end

   blkz_ctrl #(
      .SET_W(SET_W), .TAG_W(TAG_W), .LINE_WORDS(LINE_WORDS)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid),
      .req_set(eff_addr[OFF_W +: SET_W]),
      .req_tag(eff_addr[ADDR_W-1 -: TAG_W]),
      .attr_cacheable(attr_cacheable),
      .attr_write_thru(attr_write_thru),
      .perm_store_fault(perm_store_fault),
      .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
      .mem_wr_ready(mem_wr_ready), .mem_wr_err(mem_wr_err),
      .busy(busy), .done_ack(done_ack), .done_status(stat),
      .set_q(set_q), .vtag_q(vtag_q), .cnt_q(cnt_q),
      .tag_wr_en(tag_wr_en), .data_wr_en(data_wr_en),
      .mem_wr_valid(mem_wr_valid)
   );

   blkz_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .sel_set(set_q),
      .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
      .wr_en(tag_wr_en), .wr_tag(cur_tag_q)
   );

   blkz_data_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_data (
      .clk(clk), .sel_set(set_q), .sel_word(cnt_q),
      .wr_en(data_wr_en), .wr_data('0), .rd_data(mem_wr_data)
   );

   assign done_status = stat;
   assign mem_wr_addr = {vtag_q, set_q, cnt_q, {BYTE_W{1'b0}}};
endmodule

// File: rtl/blkz_unit_chk.sv
module blkz_unit_chk #(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done_ack,
   input logic [1:0]        done_status,
   input logic              mem_wr_valid,
   input logic              mem_wr_ready,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic [WORD_W-1:0] mem_wr_data
);
   logic wr_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  wr_seen <= 1'b0;
      else if (req_valid && !busy) wr_seen <= 1'b0;
      else if (mem_wr_valid)       wr_seen <= 1'b1;
   end

   assert_wr_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> busy);
   assert_beat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr));
   assert_word_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> mem_wr_addr[1:0] == 2'b00);
   assert_zero_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> mem_wr_data == '0);
   assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_ack |=> !done_ack);
   assert_ack_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_ack |-> !busy);
   assert_dse_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_ack && done_status == 2'd2 |-> !wr_seen);
   assert_align_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_ack && done_status == 2'd1 |-> !wr_seen);
endmodule

bind blkz_unit blkz_unit_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
   .done_ack(done_ack), .done_status(done_status),
   .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
   .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
);

// File: tb/blkz_unit_bench.sv
module blkz_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_base_zero = 1'b0, req_record = 1'b0;
   logic [31:0] req_base = '0, req_index = '0;
   logic        attr_cacheable = 1'b0, attr_write_thru = 1'b0, perm_store_fault = 1'b0;
   logic        busy, done_ack, mem_wr_valid;
   logic [1:0]  done_status;
   logic        mem_wr_ready = 1'b0, mem_wr_err = 1'b0;
   logic [31:0] mem_wr_addr, mem_wr_data;

   int tests = 0;
   int fails = 0;

   // reference cache state
   logic [23:0] m_tag   [8];
   bit          m_valid [8];
   bit          m_dirty [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   blkz_unit u_blkz_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
      .req_index(req_index), .req_base_zero(req_base_zero), .req_record(req_record),
      .attr_cacheable(attr_cacheable), .attr_write_thru(attr_write_thru),
      .perm_store_fault(perm_store_fault), .busy(busy), .done_ack(done_ack),
      .done_status(done_status), .mem_wr_valid(mem_wr_valid),
      .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .mem_wr_err(mem_wr_err)
   );

   task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
      end
   endtask

   // kinds: 0 storage fault, 1 alignment, 2 hit, 3 dirty victim, 4 clean miss
   task automatic do_req(input string rt, input logic [31:0] base, input logic [31:0] idx,
                         input bit bz, input bit rec, input bit c, input bit wt, input bit sf,
                         input int stall, input int err_beat);
      logic [31:0] ea;
      int          set;
      int          kind;
      logic [23:0] tg;
      logic [1:0]  exp_st;
      ea  = idx + (bz ? 32'd0 : base);
      set = int'(ea[7:5]);
      tg  = ea[31:8];
      if (sf) kind = 0;
      else if (!c || wt) kind = 1;
      else if (m_valid[set] && m_tag[set] == tg) kind = 2;
      else if (m_valid[set] && m_dirty[set]) kind = 3;
      else kind = 4;

      @(negedge clk);
      req_valid = 1'b1; req_base = base; req_index = idx; req_base_zero = bz;
      req_record = rec; attr_cacheable = c; attr_write_thru = wt; perm_store_fault = sf;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", "busy after accept", 64'(busy), 64'd1);
      chk("R9", "no ack in decide", 64'(done_ack), 64'd0);
      @(negedge clk);
      if (kind <= 1) begin
         exp_st = (kind == 0) ? 2'd2 : 2'd1;
         chk(rt, "exception ack", 64'(done_ack), 64'd1);
         chk(rt, "exception status", 64'(done_status), 64'(exp_st));
         chk(rt, "no write on exception", 64'(mem_wr_valid), 64'd0);
         chk("R9", "idle at ack", 64'(busy), 64'd0);
      end else begin
         if (kind == 3) begin
            for (int b = 0; b < 8; b++) begin
               for (int s = 0; s < stall; s++) begin
                  mem_wr_ready = 1'b0;
                  chk("R6", "beat held", 64'(mem_wr_valid), 64'd1);
                  chk("R6", "held addr", 64'(mem_wr_addr), 64'({m_tag[set], 3'(set), 3'(b), 2'b00}));
                  @(negedge clk);
               end
               mem_wr_ready = 1'b1;
               mem_wr_err   = (b == err_beat);
               chk("R6", "beat valid", 64'(mem_wr_valid), 64'd1);
               chk("R6", "beat addr", 64'(mem_wr_addr), 64'({m_tag[set], 3'(set), 3'(b), 2'b00}));
               chk("R6", "beat data", 64'(mem_wr_data), 64'd0);
               @(negedge clk);
               mem_wr_ready = 1'b0;
               mem_wr_err   = 1'b0;
            end
         end
         for (int z = 0; z < 8; z++) begin
            chk(kind == 2 ? "R4" : (kind == 3 ? "R6" : "R5"), "zeroing busy", 64'(busy), 64'd1);
            chk(kind == 2 ? "R4" : (kind == 3 ? "R6" : "R5"), "no write while zeroing", 64'(mem_wr_valid), 64'd0);
            chk("R9", "no early ack", 64'(done_ack), 64'd0);
            @(negedge clk);
         end
         exp_st = (kind == 3 && err_beat >= 0) ? 2'd3 : 2'd0;
         chk(rt, "done ack", 64'(done_ack), 64'd1);
         chk(rt, "done status", 64'(done_status), 64'(exp_st));
         chk("R9", "idle at ack", 64'(busy), 64'd0);
         m_tag[set] = tg; m_valid[set] = 1'b1; m_dirty[set] = 1'b1;
      end
      attr_cacheable = 1'b0; attr_write_thru = 1'b0; perm_store_fault = 1'b0;
      @(negedge clk);
      chk("R9", "ack one cycle", 64'(done_ack), 64'd0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin m_tag[i] = '0; m_valid[i] = 0; m_dirty[i] = 0; end
      repeat (3) @(negedge clk);
      chk("R9", "reset busy", 64'(busy), 64'd0);
      chk("R9", "reset ack", 64'(done_ack), 64'd0);
      chk("R6", "reset write", 64'(mem_wr_valid), 64'd0);
      rst_n = 1'b1;
      // R5: miss in an empty set, no memory traffic
      do_req("R5", 32'h1000, 32'h04, 0, 0, 1, 0, 0, 0, -1);
      // R4 and R1: other offset within the same block hits
      do_req("R4", 32'h1000, 32'h1F, 0, 0, 1, 0, 0, 0, -1);
      // R1: base field zero, base operand ignored
      do_req("R1", 32'hDEAD0000, 32'h2040, 1, 0, 1, 0, 0, 0, -1);
      // R6: dirty victim in set 0 written back with stalls
      do_req("R6", 32'h3000, 32'h0, 0, 0, 1, 0, 0, 2, -1);
      // R3: write-through, then not cacheable
      do_req("R3", 32'h1000, 32'h0, 0, 0, 1, 1, 0, 0, -1);
      do_req("R3", 32'h1000, 32'h0, 0, 0, 0, 0, 0, 0, -1);
      // R2: storage fault outranks write-through
      do_req("R2", 32'h1000, 32'h0, 0, 0, 1, 1, 1, 0, -1);
      // R7: victim still tag 0x30 (exceptions left set 0 alone); error on beat 3
      do_req("R7", 32'h5000, 32'h0, 0, 0, 1, 0, 0, 0, 3);
      // R8: record bit set on a hit and on a miss
      do_req("R8", 32'h5010, 32'h0, 0, 1, 1, 0, 0, 0, -1);
      do_req("R8", 32'h2060, 32'h0, 0, 1, 1, 0, 0, 1, -1);
      // R1: wrapping sum lands in set 0, evicting line installed under R7
      do_req("R1", 32'hFFFFFFF0, 32'h20, 0, 0, 1, 0, 0, 1, -1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule